// File: doc/BRIEF.md
# Output Compare Unit Pair

This block holds two compare channels that watch the count of one free-running timer. Several timers present their counts, zero strobes and peak strobes on a shared input. A select register picks the timer that both channels follow. Each channel keeps an active compare value. When the selected count equals that value while the channel is enabled, the channel sets a match flag and drives its output high. The output drops back low when the selected timer reports a count of zero. The result is one pulse per timer period, and its rising point is set by the compare value.

A new compare value can be written straight into the active register. It can also be staged in a buffer and copied over at the next zero strobe, so that the pulse never changes shape partway through a period. While a channel is disabled, its output sits at a programmed initial level. The match flag can drive an interrupt through a per-channel enable, and software clears the flag by writing a zero to it. Setup uses a single write port with five word addresses.

Top module: `ocmp_pair`

## Requirements
- R1: After reset, both outputs, both match flags and both interrupts are 0, and timer 0 is selected.
- R2: While a channel's enable bit (control bit 0) is 0, its output equals its initial-level bit (control bit 3) from one cycle after that bit is written, and its match flag never sets.
- R3: While enabled, a cycle where the selected count equals the active compare value sets the match flag and drives the output high at the next clock edge.
- R4: An enabled channel's output goes low at the clock edge after a zero strobe of the selected timer. A compare match in the same cycle takes precedence and drives the output high.
- R5: With buffer-disable (control bit 1) set to 1, a compare write (address 2 for channel 0, address 3 for channel 1) becomes the active value at the next clock edge.
- R6: With buffer-disable at 0, a compare write only loads the buffer. The active value takes the buffer contents at the clock edge after a zero strobe of the selected timer.
- R7: A control write (address 0 for channel 0, address 1 for channel 1) with bit 4 at 0 clears the match flag, and bit 4 at 1 leaves it unchanged. A match in the same cycle wins and the flag stays set.
- R8: Each interrupt output is 1 exactly when that channel's match flag and interrupt-enable bit (control bit 2) are both 1.
- R9: A write to address 4 selects the timer whose count, zero strobe and peak strobe feed both channels. A value not below the number of timers is ignored and the previous selection is kept. Writes to addresses 5 to 7 have no effect.
- R10: With the default parameters, peak strobes have no effect on the compare values or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | CNT_W | Write data |
| tmr_cnt | input | N_TIMERS*CNT_W | Timer counts, timer k in bits [k*CNT_W +: CNT_W] |
| tmr_zero | input | N_TIMERS | Per-timer zero strobes |
| tmr_peak | input | N_TIMERS | Per-timer peak strobes |
| cmp_out | output | 2 | Compare waveform outputs |
| match_flag | output | 2 | Match-detected flags |
| irq | output | 2 | Interrupt requests |

## Verification
The bench aims at same-cycle collisions. It drives a match together with a zero strobe, where a design that lets the zero win would leave the output low for a full period. It drives a flag-clear write in a match cycle, where a design that lets the clear win would lose an event. It also drives a direct compare write on a zero strobe, where the stale buffered value could overwrite the new value. Pending buffered values are checked so that they do not take effect before the selected timer wraps, and the bench confirms that strobes from unselected timers and peak strobes move nothing. Out-of-range timer selections are checked so that they do not switch the channels onto an absent timer.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
   localparam int ADDR_W = 3;
   localparam int CTRL_W = 5;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL0 = 3'd0,
      A_CTRL1 = 3'd1,
      A_CMP0  = 3'd2,
      A_CMP1  = 3'd3,
      A_TSEL  = 3'd4
   } ocmp_addr_e;

   // control word, bit 0 = en ... bit 4 = flag_keep
   typedef struct packed {
      logic flag_keep;
      logic init_lvl;
      logic ie;
      logic bdis;
      logic en;
   } ocmp_ctrl_t;
endpackage

// File: rtl/ocmp_tmr_mux.sv
module ocmp_tmr_mux #(
   parameter int CNT_W    = 16,
   parameter int N_TIMERS = 3,
   parameter int SEL_W    = 2
) (
   input  logic [N_TIMERS*CNT_W-1:0] tmr_cnt,
   input  logic [N_TIMERS-1:0]       tmr_zero,
   input  logic [N_TIMERS-1:0]       tmr_peak,
   input  logic [SEL_W-1:0]          sel,
   output logic [CNT_W-1:0]          cnt,
   output logic                      zero,
   output logic                      peak
);
   generate
      if (N_TIMERS == 1) begin : g_single
         assign cnt  = tmr_cnt[CNT_W-1:0];
         assign zero = tmr_zero[0];
         assign peak = tmr_peak[0];
      end else begin : g_multi
         always_comb begin
            cnt  = tmr_cnt[CNT_W-1:0];
            zero = tmr_zero[0];
            peak = tmr_peak[0];
            for (int k = 1; k < N_TIMERS; k++) begin
               if (sel == SEL_W'(k)) begin
                  cnt  = tmr_cnt[k*CNT_W +: CNT_W];
                  zero = tmr_zero[k];
                  peak = tmr_peak[k];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ocmp_cmp_reg.sv
module ocmp_cmp_reg #(
   parameter int CNT_W        = 16,
   parameter bit XFER_AT_PEAK = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             bdis,
   input  logic             zero,
   input  logic             peak,
   output logic [CNT_W-1:0] active
);
   logic [CNT_W-1:0] buf_q;
   logic             xfer;
   logic             direct;

   generate
      if (XFER_AT_PEAK) begin : g_xfer_both
         assign xfer = zero | peak;
      end else begin : g_xfer_zero
         assign xfer = zero;
      end
   endgenerate

   assign direct = wr & bdis;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         active <= '0;
      end else begin
         if (wr) buf_q <= wdata;
         if (direct)    active <= wdata;
         else if (xfer) active <= buf_q;
      end
   end

   // R5: an unbuffered write lands at the next edge
   a_r5_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
      direct |=> active == $past(wdata));
   // R6: the staged value moves over on a transfer event
   a_r6_buffer_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !direct) |=> active == $past(buf_q));
   // R6: without a write or a transfer event the active value holds
   a_r6_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer && !direct) |=> $stable(active));
   // R10: peak strobes alone move nothing in the default variant
   a_r10_peak_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!XFER_AT_PEAK && peak && !zero && !direct) |=> $stable(active));
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
   import ocmp_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter bit XFER_AT_PEAK = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  ocmp_ctrl_t       ctrl_wdata,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic             zero,
   input  logic             peak,
   output logic             out,
   output logic             flag,
   output logic             irq
);
   ocmp_ctrl_t       ctrl_q;
   logic [CNT_W-1:0] active;
   logic             hit;

   ocmp_cmp_reg #(
      .CNT_W       (CNT_W),
      .XFER_AT_PEAK(XFER_AT_PEAK)
   ) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cmp_wr),
      .wdata (cmp_wdata),
      .bdis  (ctrl_q.bdis),
      .zero  (zero),
      .peak  (peak),
      .active(active)
   );

   assign hit = ctrl_q.en && (cnt == active);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         flag   <= 1'b0;
         out    <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_q <= ctrl_wdata;
         if (hit)                                 flag <= 1'b1;
         else if (ctrl_wr && !ctrl_wdata.flag_keep) flag <= 1'b0;
         if (!ctrl_q.en) out <= ctrl_q.init_lvl;
         else if (hit)   out <= 1'b1;
         else if (zero)  out <= 1'b0;
      end
   end

   assign irq = flag & ctrl_q.ie;

   // R2: disabled output tracks the programmed initial level
   a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.en |=> out == $past(ctrl_q.init_lvl));
   // R2: a disabled channel never raises its flag
   a_r2_idle_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.en && !flag) |=> !flag);
   // R3: a match sets flag and output
   a_r3_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (flag && out));
   // R4: zero strobe without a match drops the output
   a_r4_zero_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.en && zero && !hit) |=> !out);
   // R7: clearing write without a match clears the flag
   a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !ctrl_wdata.flag_keep && !hit) |=> !flag);
endmodule

// File: rtl/ocmp_pair.sv
module ocmp_pair
   import ocmp_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int N_TIMERS     = 3,
   parameter bit XFER_AT_PEAK = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [CNT_W-1:0]          wr_data,
   input  logic [N_TIMERS*CNT_W-1:0] tmr_cnt,
   input  logic [N_TIMERS-1:0]       tmr_zero,
   input  logic [N_TIMERS-1:0]       tmr_peak,
   output logic [1:0]                cmp_out,
   output logic [1:0]                match_flag,
   output logic [1:0]                irq
);
   localparam int               SEL_W   = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1;
   localparam int               N_CH    = 2;
   localparam logic [CNT_W-1:0] N_TIM_W = CNT_W'(N_TIMERS);

   generate
      if (CNT_W < CTRL_W) begin : g_bad_width
         $error("CNT_W must be at least the control word width");
      end
      if (N_TIMERS < 1) begin : g_bad_timers
         $error("N_TIMERS must be at least 1");
      end
   endgenerate

   logic [SEL_W-1:0] tsel_q;
   logic [CNT_W-1:0] sel_cnt;
   logic             sel_zero;
   logic             sel_peak;
   logic             tsel_wr;

   assign tsel_wr = wr_en && (wr_addr == A_TSEL) && (wr_data < N_TIM_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tsel_q <= '0;
      else if (tsel_wr) tsel_q <= wr_data[SEL_W-1:0];
   end

   ocmp_tmr_mux #(
      .CNT_W   (CNT_W),
      .N_TIMERS(N_TIMERS),
      .SEL_W   (SEL_W)
   ) u_mux (
      .tmr_cnt (tmr_cnt),
      .tmr_zero(tmr_zero),
      .tmr_peak(tmr_peak),
      .sel     (tsel_q),
      .cnt     (sel_cnt),
      .zero    (sel_zero),
      .peak    (sel_peak)
   );

   generate
      for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
         logic ctrl_wr;
         logic cmp_wr;
         assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(A_CTRL0 + ch));
         assign cmp_wr  = wr_en && (wr_addr == ADDR_W'(A_CMP0 + ch));

         ocmp_channel #(
            .CNT_W       (CNT_W),
            .XFER_AT_PEAK(XFER_AT_PEAK)
         ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl_wr   (ctrl_wr),
            .ctrl_wdata(ocmp_ctrl_t'(wr_data[CTRL_W-1:0])),
            .cmp_wr    (cmp_wr),
            .cmp_wdata (wr_data),
            .cnt       (sel_cnt),
            .zero      (sel_zero),
            .peak      (sel_peak),
            .out       (cmp_out[ch]),
            .flag      (match_flag[ch]),
            .irq       (irq[ch])
         );
      end
   endgenerate

   // R9: the selection never points at an absent timer
   a_r9_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      tsel_q < SEL_W'(N_TIMERS - 1) || tsel_q == SEL_W'(N_TIMERS - 1));
   // R9: an out-of-range write keeps the selection
   a_r9_bad_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_TSEL && !(wr_data < N_TIM_W)) |=> $stable(tsel_q));
   // R8: no interrupt without a flag
   a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (irq & ~match_flag) == 2'b00);
endmodule

// File: tb/ocmp_pair_test.sv
module ocmp_pair_test;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;
   localparam int NT         = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [2:0]        wr_addr = '0;
   logic [CNT_W-1:0]  wr_data = '0;
   logic [NT*CNT_W-1:0] tmr_cnt = '0;
   logic [NT-1:0]     tmr_zero = '0;
   logic [NT-1:0]     tmr_peak = '0;
   logic [1:0]        cmp_out, match_flag, irq;

   ocmp_pair #(.CNT_W(CNT_W), .N_TIMERS(NT)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tmr_cnt(tmr_cnt), .tmr_zero(tmr_zero),
      .tmr_peak(tmr_peak), .cmp_out(cmp_out), .match_flag(match_flag), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference state
   logic             m_en[2], m_bdis[2], m_ie[2], m_init[2], m_flag[2], m_out[2];
   logic [CNT_W-1:0] m_act[2], m_buf[2];
   int               m_sel;

   // stimulus variables
   int  tc[NT];
   int  per[NT];

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < 2; c++) begin
         m_en[c] = 0; m_bdis[c] = 0; m_ie[c] = 0; m_init[c] = 0;
         m_flag[c] = 0; m_out[c] = 0; m_act[c] = '0; m_buf[c] = '0;
      end
      m_sel = 0;
   endtask

   function automatic logic [CNT_W-1:0] cnt_of(input int t);
      return tmr_cnt[t*CNT_W +: CNT_W];
   endfunction

   // apply current inputs, advance the model one edge, check at the next negedge
   task automatic step(input string tag);
      logic             n_en[2], n_bdis[2], n_ie[2], n_init[2], n_flag[2], n_out[2];
      logic [CNT_W-1:0] n_act[2], n_buf[2];
      int               n_sel;
      logic             z;
      z = tmr_zero[m_sel];
      n_sel = m_sel;
      if (wr_en && wr_addr == 3'd4 && wr_data < NT) n_sel = int'(wr_data);
      for (int c = 0; c < 2; c++) begin
         logic hit, cw, kw;
         hit = m_en[c] && (cnt_of(m_sel) == m_act[c]);
         cw  = wr_en && wr_addr == 3'(c);
         kw  = wr_en && wr_addr == 3'(2 + c);
         n_en[c] = m_en[c]; n_bdis[c] = m_bdis[c]; n_ie[c] = m_ie[c]; n_init[c] = m_init[c];
         if (cw) begin
            n_en[c] = wr_data[0]; n_bdis[c] = wr_data[1];
            n_ie[c] = wr_data[2]; n_init[c] = wr_data[3];
         end
         n_buf[c] = kw ? wr_data : m_buf[c];
         if (kw && m_bdis[c]) n_act[c] = wr_data;
         else if (z)          n_act[c] = m_buf[c];
         else                 n_act[c] = m_act[c];
         if (hit)                   n_flag[c] = 1;
         else if (cw && !wr_data[4]) n_flag[c] = 0;
         else                       n_flag[c] = m_flag[c];
         if (!m_en[c])   n_out[c] = m_init[c];
         else if (hit)   n_out[c] = 1;
         else if (z)     n_out[c] = 0;
         else            n_out[c] = m_out[c];
      end
      m_en = n_en; m_bdis = n_bdis; m_ie = n_ie; m_init = n_init;
      m_flag = n_flag; m_out = n_out; m_act = n_act; m_buf = n_buf; m_sel = n_sel;
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
         chk(tag, $sformatf("cmp_out[%0d]", c), int'(cmp_out[c]), int'(m_out[c]));
         chk(tag, $sformatf("match_flag[%0d]", c), int'(match_flag[c]), int'(m_flag[c]));
         chk(tag, $sformatf("irq[%0d] R8", c), int'(irq[c]), int'(m_flag[c] & m_ie[c]));
      end
      wr_en = 1'b0;
   endtask

   task automatic set_tmr(input int t, input int v, input bit z, input bit p);
      tmr_cnt[t*CNT_W +: CNT_W] = CNT_W'(v);
      tmr_zero[t] = z;
      tmr_peak[t] = p;
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = CNT_W'(d);
   endtask

   task automatic quiet();
      for (int t = 0; t < NT; t++) set_tmr(t, 100, 0, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240611));
      model_reset();
      quiet();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "cmp_out", int'(cmp_out), 0);
      chk("R1", "match_flag", int'(match_flag), 0);
      chk("R1", "irq", int'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      step("R1");

      // R2: disabled, init level 1, count equals reset compare 0
      wr(0, 5'b01000); step("R2");
      set_tmr(0, 0, 1, 0); step("R2");
      step("R2");
      quiet();
      // R5: enable direct writes on ch0, compare 5
      wr(0, 5'b00111); step("R5");
      wr(2, 5); step("R5");
      // R3: hit on selected timer 0
      set_tmr(0, 5, 0, 0); step("R3");
      quiet(); step("R3");
      // R4: zero strobe drops output
      set_tmr(0, 1, 1, 0); step("R4");
      // R4: match and zero together -> match wins
      set_tmr(0, 5, 1, 0); step("R4");
      quiet();
      // R7: keep-bit write leaves flag, clear write clears
      wr(0, 5'b10111); step("R7");
      wr(0, 5'b00111); step("R7");
      // R7: clear during a match -> flag stays
      wr(0, 5'b00111); set_tmr(0, 5, 0, 0); step("R7");
      quiet();
      // R6: buffered ch1, compare 9 staged, not active until zero
      wr(1, 5'b00101); step("R6");
      wr(3, 9); step("R6");
      set_tmr(0, 9, 0, 0); step("R6");
      set_tmr(0, 9, 0, 1); step("R10");
      set_tmr(1, 0, 1, 1); step("R9");
      set_tmr(0, 3, 1, 0); step("R6");
      set_tmr(0, 9, 0, 0); step("R6");
      quiet();
      // R9: select timer 2, invalid select 3 ignored, invalid address ignored
      wr(4, 2); step("R9");
      wr(4, 3); step("R9");
      wr(6, 5'b11111); step("R9");
      set_tmr(2, 9, 0, 0); step("R9");
      set_tmr(0, 5, 1, 0); step("R9");
      quiet();

      // random phase
      per[0] = 9; per[1] = 12; per[2] = 15;
      for (int t = 0; t < NT; t++) tc[t] = int'($urandom % 8);
      for (int i = 0; i < 4000; i++) begin
         for (int t = 0; t < NT; t++) begin
            tc[t] = (tc[t] >= per[t]) ? 0 : tc[t] + 1;
            set_tmr(t, tc[t], tc[t] == 0, tc[t] == per[t]);
         end
         if ($urandom % 4 == 0) begin
            int a;
            a = int'($urandom % 8);
            case (a)
               0, 1:    wr(a, int'($urandom % 32));
               2, 3:    wr(a, int'($urandom % 16));
               4:       wr(a, int'($urandom % 4));
               default: wr(a, int'($urandom % 32));
            endcase
         end
         step("R3 R4 R5 R6 R7 R9 R10");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule